// File: doc/BRIEF.md
# Process-ID Address Segmentation Unit

This unit sits between a processor's 32-bit program address and the external page-mapping bus. It confines each process to a window of a 16M-word virtual space. When mapping is on, the top `n` bits of the 24-bit word address are replaced by the low `n` bits of a process identifier. The remaining `24-n` bits are kept as the in-process offset, so every process sees a window of 2^(24-n) words.

The window is split in two halves. One half sits at the bottom of the 32-bit program space and the other at its top. An address is legal only if its bits 31 down to `23-n` are either all zero or all one. Any address between the two halves raises a fault flag, which the external mapping logic treats as a page fault.

The identifier and `n` are held in configuration registers that accept writes only at supervisor privilege. The translated address, a request-valid flag, the fault flag, the privilege tag and the mapping-enable tag are all registered together. Each output therefore describes the same memory cycle, one clock after the request.

Top module: `pid_seg_map`

## Requirements
- R1: While `rst_ni` is low, every output is 0, and the identifier and `n` registers reset to 0. After reset with mapping on, an address whose bits 31..23 are uniform passes its low 24 bits unchanged.
- R2: A configuration write with `cfg_we_i=1` and `priv_i=1` (supervisor) loads `cfg_pid_i` and `cfg_n_i` at the next clock edge.
- R3: A configuration write with `priv_i=0` (user) leaves the identifier and `n` unchanged.
- R4: A supervisor write whose `cfg_n_i` exceeds `PID_MAX_W` (8) is ignored as a whole.
- R5: With mapping on, `va_o` bits [23:24-n] equal identifier bits [n-1:0], and `va_o` bits [23-n:0] equal program address bits [23-n:0].
- R6: With mapping on and a request present, `fault_o` is 1 exactly when program address bits [31:23-n] are neither all zero nor all one.
- R7: With mapping off, `va_o` equals program address bits [23:0] and `fault_o` is 0.
- R8: Every output reflects the inputs of the previous clock edge, and `va_valid_o` follows `req_valid_i` with one cycle of delay.
- R9: `priv_o` and `map_o` carry the `priv_i` and `map_en_i` values of the same request as `va_o`.
- R10: `fault_o` is 0 in any cycle whose request flag was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_addr_i | input | 32 | Program word address |
| req_valid_i | input | 1 | A memory reference is present this cycle |
| map_en_i | input | 1 | Segmentation enabled |
| priv_i | input | 1 | Current privilege, 1 = supervisor |
| cfg_we_i | input | 1 | Write strobe for the identifier and n registers |
| cfg_pid_i | input | 8 | Identifier to load |
| cfg_n_i | input | 4 | Identifier width n to load (0..8) |
| va_o | output | 24 | Virtual word address |
| va_valid_o | output | 1 | Registered request flag |
| fault_o | output | 1 | Address outside both valid halves |
| priv_o | output | 1 | Registered privilege tag |
| map_o | output | 1 | Registered mapping-enable tag |

## Verification
The bench builds the unit with its default parameters: a 32-bit program address, a 24-bit virtual address and an identifier of up to 8 bits. This lets it sweep every legal `n` from 0 to 8 against several identifiers. For each `n` it drives the exact edges of both halves: the last bottom word, the first faulting word, the last faulting word and the first top word. Hashed mid-range addresses are added. The expected window arithmetic uses 64-bit integers, so the checks for the 64K-word and 16M-word extremes are exact. Rejected writes, whether from user privilege or an out-of-range `n`, are observed afterwards through the translated address.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int PA_W_DEF      = 32;
  localparam int VA_W_DEF      = 24;
  localparam int PID_MAX_W_DEF = 8;
  localparam int NSEL_W_DEF    = $clog2(PID_MAX_W_DEF + 1);
endpackage

// File: rtl/seg_cfg.sv
module seg_cfg #(
  parameter int PID_W  = 8,
  parameter int NSEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [NSEL_W-1:0] n_i,
  output logic [PID_W-1:0]  pid_o,
  output logic [NSEL_W-1:0] n_o
);
  localparam logic [NSEL_W-1:0] N_MAX = NSEL_W'(PID_W);

  logic accept;
  assign accept = we_i && priv_i && (n_i <= N_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pid_o <= '0;
      n_o   <= '0;
    end else if (accept) begin
      pid_o <= pid_i;
      n_o   <= n_i;
    end
  end

  AST_USER_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i) |=> ($stable(pid_o) && $stable(n_o))); // R3
  AST_N_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_o <= N_MAX); // R4
  AST_SUP_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && priv_i && n_i <= N_MAX) |=> (pid_o == $past(pid_i))); // R2
endmodule

// File: rtl/seg_range.sv
module seg_range #(
  parameter int PA_W   = 32,
  parameter int VA_W   = 24,
  parameter int NSEL_W = 4
) (
  input  logic [PA_W-1:0]   addr_i,
  input  logic [NSEL_W-1:0] n_i,
  output logic              ok_o
);
  // bits [PA_W-1 : VA_W-1-n] must be uniform
  logic [PA_W-1:0] chk_mask;
  logic [PA_W-1:0] hi_bits;

  for (genvar g = 0; g < PA_W; g++) begin : g_mask
    assign chk_mask[g] = ((g + int'(n_i)) >= (VA_W - 1));
  end

  assign hi_bits = addr_i & chk_mask;
  assign ok_o    = (hi_bits == '0) || (hi_bits == chk_mask);
endmodule

// File: rtl/seg_compose.sv
module seg_compose #(
  parameter int PA_W   = 32,
  parameter int VA_W   = 24,
  parameter int PID_W  = 8,
  parameter int NSEL_W = 4
) (
  input  logic [PA_W-1:0]   addr_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [NSEL_W-1:0] n_i,
  input  logic              map_i,
  output logic [VA_W-1:0]   va_o
);
  logic [VA_W-1:0] keep;
  logic [VA_W-1:0] pid_ext;
  logic [VA_W-1:0] pid_sh;

  for (genvar g = 0; g < VA_W; g++) begin : g_keep
    assign keep[g] = ((g + int'(n_i)) < VA_W);
  end

  assign pid_ext = {{(VA_W-PID_W){1'b0}}, pid_i};
  assign pid_sh  = pid_ext << (VA_W - int'(n_i));

  always_comb begin
    if (map_i) va_o = (addr_i[VA_W-1:0] & keep) | (pid_sh & ~keep);
    else       va_o = addr_i[VA_W-1:0];
  end
endmodule

// File: rtl/pid_seg_map.sv
module pid_seg_map
  import seg_pkg::*;
#(
  parameter int PA_W      = PA_W_DEF,
  parameter int VA_W      = VA_W_DEF,
  parameter int PID_MAX_W = PID_MAX_W_DEF,
  parameter int NSEL_W    = $clog2(PID_MAX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PA_W-1:0]   prog_addr_i,
  input  logic              req_valid_i,
  input  logic              map_en_i,
  input  logic              priv_i,
  input  logic              cfg_we_i,
  input  logic [PID_MAX_W-1:0] cfg_pid_i,
  input  logic [NSEL_W-1:0] cfg_n_i,
  output logic [VA_W-1:0]   va_o,
  output logic              va_valid_o,
  output logic              fault_o,
  output logic              priv_o,
  output logic              map_o
);
  logic [PID_MAX_W-1:0] pid_q;
  logic [NSEL_W-1:0]    n_q;
  logic                 in_window;
  logic [VA_W-1:0]      va_d;

  seg_cfg #(.PID_W(PID_MAX_W), .NSEL_W(NSEL_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .priv_i(priv_i), .pid_i(cfg_pid_i), .n_i(cfg_n_i),
    .pid_o(pid_q), .n_o(n_q)
  );

  seg_range #(.PA_W(PA_W), .VA_W(VA_W), .NSEL_W(NSEL_W)) u_range (
    .addr_i(prog_addr_i), .n_i(n_q), .ok_o(in_window)
  );

  seg_compose #(.PA_W(PA_W), .VA_W(VA_W), .PID_W(PID_MAX_W), .NSEL_W(NSEL_W)) u_compose (
    .addr_i(prog_addr_i), .pid_i(pid_q), .n_i(n_q), .map_i(map_en_i), .va_o(va_d)
  );

  // address, flags and fault share one stage to stay cycle-aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_o       <= '0;
      va_valid_o <= 1'b0;
      fault_o    <= 1'b0;
      priv_o     <= 1'b0;
      map_o      <= 1'b0;
    end else begin
      va_o       <= va_d;
      va_valid_o <= req_valid_i;
      fault_o    <= req_valid_i && map_en_i && !in_window;
      priv_o     <= priv_i;
      map_o      <= map_en_i;
    end
  end

  AST_FAULT_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (va_valid_o && map_o)); // R6
  AST_NO_REQ_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!fault_o && !va_valid_o)); // R10
  AST_REQ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> va_valid_o); // R8
  AST_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_en_i |=> (!fault_o && va_o == $past(prog_addr_i[VA_W-1:0]))); // R7
  AST_TAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (priv_o == $past(priv_i) && map_o == $past(map_en_i))); // R9
endmodule

// File: tb/pid_seg_map_bench.sv
module pid_seg_map_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] prog_addr;
  logic        req_valid, map_en, priv, cfg_we;
  logic [7:0]  cfg_pid;
  logic [3:0]  cfg_n;
  logic [23:0] va;
  logic        va_valid, fault, priv_t, map_t;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pid_seg_map u_pid_seg_map (
    .clk_i(clk), .rst_ni(rst_ni), .prog_addr_i(prog_addr), .req_valid_i(req_valid),
    .map_en_i(map_en), .priv_i(priv), .cfg_we_i(cfg_we), .cfg_pid_i(cfg_pid),
    .cfg_n_i(cfg_n), .va_o(va), .va_valid_o(va_valid), .fault_o(fault),
    .priv_o(priv_t), .map_o(map_t)
  );

  function automatic bit exp_ok(longint a, int n);
    longint h = longint'(1) << (23 - n);
    return (a < h) || (a >= (longint'(1) << 32) - h);
  endfunction

  function automatic longint exp_va(longint a, longint pid, int n, bit m);
    if (!m) return a % (longint'(1) << 24);
    return (pid % (longint'(1) << n)) * (longint'(1) << (24 - n)) + a % (longint'(1) << (24 - n));
  endfunction

  task automatic check(string req, logic [23:0] e_va, logic e_v, logic e_f, logic e_p, logic e_m);
    vectors++;
    if (va !== e_va || va_valid !== e_v || fault !== e_f || priv_t !== e_p || map_t !== e_m) begin
      miscompares++;
      $display("FAIL %s: got va=%h v=%b f=%b p=%b m=%b exp va=%h v=%b f=%b p=%b m=%b",
               req, va, va_valid, fault, priv_t, map_t, e_va, e_v, e_f, e_p, e_m);
    end
  endtask

  task automatic write_cfg(logic [7:0] pid, logic [3:0] n, logic p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pid = pid; cfg_n = n; priv = p; req_valid = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(string req, logic [31:0] a, logic r, logic m, logic p,
                       longint pid, int n);
    logic [23:0] e_va;
    logic e_f;
    prog_addr = a; req_valid = r; map_en = m; priv = p;
    @(negedge clk);
    e_va = 24'(exp_va(longint'(a), pid, n, m));
    e_f  = r && m && !exp_ok(longint'(a), n);
    check(req, e_va, r, e_f, p, m);
  endtask

  function automatic logic [31:0] pick(int k, int n, int seed);
    logic [31:0] h = 32'h1 << (23 - n);
    case (k)
      0: return 32'h0;
      1: return h - 32'h1;
      2: return h;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF - h;
      5: return 32'hFFFF_FFFF - h + 32'h1;
      6: return 32'hFFFF_FFFF;
      default: return 32'(seed) * 32'h9E37_79B9 + 32'h0123_4567;
    endcase
  endfunction

  initial begin
    prog_addr = '0; req_valid = 0; map_en = 0; priv = 0; cfg_we = 0; cfg_pid = '0; cfg_n = '0;
    #12;
    check("R1 reset", 24'h0, 0, 0, 0, 0);
    @(negedge clk); rst_ni = 1'b1;
    // R1: reset config n=0, pid=0
    apply("R1 n0", 32'h00AB_CDEF, 1, 1, 0, 0, 0);
    apply("R1 n0 top", 32'hFFAB_CDEF, 1, 1, 0, 0, 0);

    for (int n = 0; n <= 8; n++) begin
      for (int pi = 0; pi < 3; pi++) begin
        logic [7:0] pid = (pi == 0) ? 8'hFF : (pi == 1) ? 8'hA5 : 8'(8'h3C + n);
        write_cfg(pid, 4'(n), 1'b1); // R2
        for (int k = 0; k < 10; k++) begin
          apply("R5 R6 sweep", pick(k, n, n * 31 + pi * 7 + k), 1, 1, k[0], longint'(pid), n);
        end
        apply("R7 passthru", pick(3, n, 0), 1, 0, 1, longint'(pid), n);
        apply("R10 no req", pick(3, n, 0), 0, 1, 0, longint'(pid), n);
      end
    end

    write_cfg(8'h5A, 4'd4, 1'b1);
    apply("R2 load", 32'h0001_2345, 1, 1, 1, 'h5A, 4);
    write_cfg(8'hC3, 4'd6, 1'b0);
    apply("R3 user write ignored", 32'h0001_2345, 1, 1, 0, 'h5A, 4);
    apply("R3 user write ignored fault", 32'h0080_0000, 1, 1, 0, 'h5A, 4);
    write_cfg(8'h11, 4'd9, 1'b1);
    apply("R4 n>8 ignored", 32'h0001_2345, 1, 1, 1, 'h5A, 4);
    write_cfg(8'h11, 4'd15, 1'b1);
    apply("R4 n=15 ignored", 32'hFFFF_FFF0, 1, 1, 0, 'h5A, 4);
    // R8 R9: back-to-back requests with changing tags
    apply("R8 R9 b2b", 32'h0000_0001, 1, 1, 1, 'h5A, 4);
    apply("R8 R9 b2b", 32'h4000_0000, 1, 1, 0, 'h5A, 4);
    apply("R8 R9 b2b", 32'h4000_0000, 1, 0, 1, 'h5A, 4);
    apply("R8 R9 b2b", 32'h4000_0000, 0, 0, 0, 'h5A, 4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule